// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between a serial transmit data line and the driver of a single-wire LIN bus. Its job is to stop the bus from staying dominant for good when the data line is stuck LOW by a hardware or software fault. A LOW level on the transmit data line asks for a dominant bus. The guard passes that request to the driver only while the mode controller enables the transmitter and no time-out is active.

A falling edge on the data line arms a cycle counter. If the line is still LOW after `TIMEOUT_CYCLES` clock edges, the guard latches a time-out flag and forces the drive output recessive. The flag stays set, and the drive stays off, for as long as the line remains LOW. The first clock edge that samples the line HIGH clears both the flag and the counter. The counter stops at the limit, so it never wraps.

The data input is expected to be synchronous to `clk` already. The drive output is combinational from the data input, so it adds no latency to the transmit path.

Top module: `txd_dom_guard`

## Requirements
- R1: `busDrive` is 1 (dominant) exactly when `txEnable` is 1, `txdIn` is 0 and `timedOut` is 0; it follows `txdIn` and `txEnable` in the same cycle, with no clock edge in between.
- R2: A clock edge that samples `txdIn` at 0 after a sample at 1 arms the timer. `timedOut` goes to 1 at the `TIMEOUT_CYCLES`-th consecutive clock edge that samples `txdIn` at 0, and not at any earlier edge.
- R3: Once `timedOut` is 1, it stays 1 and `busDrive` stays 0 for every further edge at which `txdIn` is still sampled at 0, however long the line stays LOW and whatever `txEnable` does.
- R4: The first clock edge that samples `txdIn` at 1 clears `timedOut` and the timer. The next LOW period then gets the full `TIMEOUT_CYCLES` window again.
- R5: `txEnable` has no effect on the timer or on `timedOut`; it only gates `busDrive`.
- R6: An active-low `rstN` clears `timedOut` and the timer at once. If `txdIn` is 0 when reset is released, that level counts as a new falling edge and gets a full window.
- R7: `busDrive` is never sampled at 1 on more than `TIMEOUT_CYCLES` consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| txdIn | input | 1 | Synchronized transmit data; 0 requests dominant |
| txEnable | input | 1 | Transmitter enable from the mode controller |
| busDrive | output | 1 | 1 drives the bus dominant, 0 leaves it recessive |
| timedOut | output | 1 | Sticky time-out status; 1 while the drive is forced off |

## Verification
`busDrive` is combinational, so the bench checks it one time unit after driving the inputs on the falling clock edge. `timedOut` changes only at a rising edge, so it is checked one time unit after the k-th rising edge that sampled the line LOW, where the expected value is simply k >= `TIMEOUT_CYCLES`. The release is checked one time unit after the first rising edge that samples the line HIGH. The sweep covers every LOW length from one cycle to three past the limit, with the enable both off and on.

// File: rtl/txd_dom_guard_pkg.sv
package txd_dom_guard_pkg;

  // Strobes from control to datapath, one per counter action
  typedef struct packed {
    logic clear;  // line sampled HIGH: zero the timer
    logic start;  // falling edge seen: load first count
    logic step;   // line still LOW and below limit: advance
  } guardStrobeT;

endpackage

// File: rtl/txd_dom_guard_dp.sv
module txd_dom_guard_dp
  import txd_dom_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  guardStrobeT strobe,
  output logic        cntSat,
  output logic        hitLimit
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] lowCntNext;

  always_comb begin
    lowCntNext = lowCnt;
    if (strobe.clear) begin
      lowCntNext = '0;
    end else if (strobe.start) begin
      lowCntNext = ONE;
    end else if (strobe.step) begin
      lowCntNext = lowCnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else begin
      lowCnt <= lowCntNext;
    end
  end

  assign cntSat   = (lowCnt == LIMIT);
  assign hitLimit = (lowCntNext == LIMIT);

endmodule

// File: rtl/txd_dom_guard_ctrl.sv
module txd_dom_guard_ctrl
  import txd_dom_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txdIn,
  input  logic        txEnable,
  input  logic        cntSat,
  input  logic        hitLimit,
  output guardStrobeT strobe,
  output logic        busDrive,
  output logic        timedOut
);

  logic txdPrev;
  logic timedOutNext;

  // Previous level resets HIGH so a LOW line at release counts as a new edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txdPrev <= 1'b1;
    end else begin
      txdPrev <= txdIn;
    end
  end

  always_comb begin
    strobe.clear = txdIn;
    strobe.start = !txdIn && txdPrev;
    strobe.step  = !txdIn && !txdPrev && !cntSat;
  end

  always_comb begin
    if (txdIn) begin
      timedOutNext = 1'b0;
    end else begin
      timedOutNext = timedOut || hitLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timedOut <= 1'b0;
    end else begin
      timedOut <= timedOutNext;
    end
  end

  assign busDrive = txEnable && !txdIn && !timedOut;

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
  import txd_dom_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdIn,
  input  logic txEnable,
  output logic busDrive,
  output logic timedOut
);

  guardStrobeT strobe;
  logic        cntSat;
  logic        hitLimit;

  txd_dom_guard_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txdIn    (txdIn),
    .txEnable (txEnable),
    .cntSat   (cntSat),
    .hitLimit (hitLimit),
    .strobe   (strobe),
    .busDrive (busDrive),
    .timedOut (timedOut)
  );

  txd_dom_guard_dp #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntSat   (cntSat),
    .hitLimit (hitLimit)
  );

endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk #(
  parameter int unsigned TIMEOUT_CYCLES = 2000
) (
  input logic clk,
  input logic rstN,
  input logic txdIn,
  input logic txEnable,
  input logic busDrive,
  input logic timedOut
);

  localparam int unsigned RUN_W = $clog2(TIMEOUT_CYCLES + 2);
  localparam logic [RUN_W-1:0] LIM = RUN_W'(TIMEOUT_CYCLES);

  logic [RUN_W-1:0] lowRun;
  logic [RUN_W-1:0] driveRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun   <= '0;
      driveRun <= '0;
    end else begin
      lowRun   <= txdIn ? '0 : ((lowRun >= LIM) ? lowRun : lowRun + 1'b1);
      driveRun <= !busDrive ? '0 : ((driveRun > LIM) ? driveRun : driveRun + 1'b1);
    end
  end

  // R1
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (txEnable && !txdIn && !timedOut));

  // R2
  timeout_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    timedOut == (lowRun >= LIM));

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timedOut && !txdIn) |=> timedOut);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    txdIn |=> !timedOut);

  // R7
  drive_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDrive |-> (driveRun < LIM));

endmodule

bind txd_dom_guard txd_dom_guard_chk #(
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .txdIn    (txdIn),
  .txEnable (txEnable),
  .busDrive (busDrive),
  .timedOut (timedOut)
);

// File: tb/txd_dom_guard_test.sv
module txd_dom_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 5;

  logic clk = 1'b0;
  logic rstN;
  logic txdIn;
  logic txEnable;
  logic busDrive;
  logic timedOut;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD / 2) clk = !clk;

  txd_dom_guard #(
    .TIMEOUT_CYCLES (LIMIT)
  ) uut (
    .clk      (clk),
    .rstN     (rstN),
    .txdIn    (txdIn),
    .txEnable (txEnable),
    .busDrive (busDrive),
    .timedOut (timedOut)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Holds the line LOW for lowLen edges, then releases it
  task automatic lowPulse(input logic en, input int lowLen);
    @(negedge clk);
    txEnable = en;
    txdIn    = 1'b0;
    #1;
    check("R1", "drive before first edge", busDrive, en);
    for (int k = 1; k <= lowLen; k++) begin
      @(posedge clk);
      #1;
      check((k >= LIMIT) ? "R3" : "R2", "timedOut", timedOut, logic'(k >= LIMIT));
      check((k >= LIMIT) ? "R3" : "R1", "busDrive", busDrive, logic'(en && (k < LIMIT)));
    end
    @(negedge clk);
    txdIn = 1'b1;
    @(posedge clk);
    #1;
    check("R4", "timedOut after release", timedOut, 1'b0);
    check("R4", "busDrive after release", busDrive, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    txdIn    = 1'b1;
    txEnable = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R6", "timedOut after reset", timedOut, 1'b0);
    check("R6", "busDrive after reset", busDrive, 1'b0);

    // R2 R3 R4 R1 sweep over every LOW length and both enable levels
    for (int en = 0; en < 2; en++) begin
      for (int len = 1; len <= LIMIT + 3; len++) begin
        lowPulse(logic'(en), len);
      end
    end

    // R5: timer runs while disabled; enabling late does not extend it
    @(negedge clk);
    txEnable = 1'b0;
    txdIn    = 1'b0;
    for (int k = 1; k <= LIMIT; k++) begin
      @(posedge clk);
      #1;
      check("R5", "timedOut with enable toggled", timedOut, logic'(k >= LIMIT));
      @(negedge clk);
      txEnable = (k >= LIMIT - 2);
      #1;
      check("R5", "busDrive with enable toggled", busDrive, logic'((k >= LIMIT - 2) && (k < LIMIT)));
    end
    // R3: enable toggling after time-out keeps drive off
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      txEnable = k[0];
      #1;
      check("R3", "busDrive while timed out", busDrive, 1'b0);
      check("R3", "timedOut while timed out", timedOut, 1'b1);
    end
    @(negedge clk);
    txdIn = 1'b1;
    @(posedge clk);
    #1;
    check("R4", "release after enable test", timedOut, 1'b0);

    // R6: reset during time-out, line LOW at release gets full window
    @(negedge clk);
    txEnable = 1'b1;
    txdIn    = 1'b0;
    repeat (LIMIT + 2) @(posedge clk);
    #1;
    check("R3", "timedOut before reset", timedOut, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R6", "timedOut in reset", timedOut, 1'b0);
    check("R6", "busDrive in reset", busDrive, 1'b1);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 1; k <= LIMIT + 1; k++) begin
      @(posedge clk);
      #1;
      check("R6", "timedOut after reset release", timedOut, logic'(k >= LIMIT));
      check("R7", "busDrive after reset release", busDrive, logic'(k < LIMIT));
    end
    @(negedge clk);
    txdIn = 1'b1;
    @(posedge clk);
    #1;
    check("R4", "final release", timedOut, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule